// File: doc/BRIEF.md
# PLL Rate Change Sequencer

This block carries out a frequency change on one of four PLL channels. A request names a voltage domain, a change mode and a setting that has already been computed (a 3-bit post-divider code and a 22-bit frequency control word). The block turns the domain into a channel number, then issues a sequence of register-style write strobes toward that channel's PLL control logic. Between writes it waits settle intervals that are counted in clock cycles. In the hardware hopping mode it also watches a monitor value until the PLL reports that it reached the new word, and it gives up after a bounded window.

Three modes exist. Direct mode rewrites the whole control word and then lets the PLL settle. Software hopping mode takes the PLL down, reprograms the hopping target and the divider, pulses a toggle, and brings the PLL back up. Hardware hopping mode hands the new word to the hopping engine; it writes the divider either before or after the target, depending on whether the divider code goes up. The block keeps a shadow copy of the last post-divider written to each channel, so that it can make this comparison without a read cycle.

A single engine serves all four channels. While it is busy, new requests are ignored, so two domains that share a channel can never overlap on it.

Top module: `pll_rate_seq`

## Requirements
- R1: Domain codes map to channels as follows: 0 and 1 go to channel 0, 2 and 3 go to channel 1, 4 goes to channel 2, and 5 goes to channel 3. The selected channel appears on `wr_ch` for every write of the request.
- R2: Domain codes 6 and 7 produce `done` in the cycle after acceptance with status 1 (bad domain) and no write. This check takes priority over the mode check.
- R3: Mode code 3 with a valid domain produces `done` in the cycle after acceptance with status 2 (bad mode) and no write.
- R4: Direct mode (mode 0) issues exactly one write of kind 0. Its data is the change flag in bit 31, the post-divider in bits 26:24 and the control word in bits 21:0, with every other bit zero. `done` with status 0 follows 20·CYC_PER_US+1 cycles after that write.
- R5: Software hopping (mode 1) issues five writes in consecutive order: kind 4 with data 0 (PLL disable), kind 2 with the target word, kind 1 with the post-divider in bits 2:0, kind 2 with the target word plus the toggle bit 30, and kind 4 with data 1. The target word is bit 31 set plus the control word in bits 21:0.
- R6: In software hopping, the enable write comes CYC_PER_US+1 cycles after the toggle write, and `done` with status 0 follows 20·CYC_PER_US+1 cycles after the enable write.
- R7: In hardware hopping (mode 2), when the new post-divider code is greater than the channel's shadow value, the block writes kind 1 (divider) first and then kind 3 (hardware hopping target, same format as the target word).
- R8: In hardware hopping, when the new code is equal to or less than the shadow value, the block writes kind 3 first and kind 1 second. The shadow holds the last divider written to that channel by any mode and is 0 after reset.
- R9: After the two hardware writes, the block polls `mon_data[21:0]`. On a match with the control word it ends with status 0; when the monitor already matches, `done` comes 2 cycles after the second write.
- R10: If the monitor does not match within 20·CYC_PER_US polling cycles, `done` comes 20·CYC_PER_US+1 cycles after the second write with status 3 (timeout).
- R11: `busy` is high from the cycle after acceptance until `done`. A request presented while `busy` is high is ignored: it causes no write and no extra `done`.
- R12: After reset `busy`, `done` and `wr_en` are low. `done` is a single-cycle pulse that occurs only while `busy` is low, and `wr_ch` is stable across consecutive writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_domain | input | 3 | Voltage-domain code |
| req_mode | input | 2 | 0 direct, 1 software hopping, 2 hardware hopping |
| req_postdiv | input | PD_W | New post-divider code |
| req_pcw | input | PCW_W | New frequency control word |
| busy | output | 1 | A request is in progress |
| wr_en | output | 1 | Write strobe |
| wr_kind | output | 3 | 0 control word, 1 divider field, 2 software target, 3 hardware target, 4 enable |
| wr_ch | output | 2 | Channel addressed by the write and the monitor |
| wr_data | output | 32 | Write data |
| mon_data | input | 32 | Monitor of the channel on `wr_ch` |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad domain, 2 bad mode, 3 timeout |

## Verification
Each result has a fixed latency in cycles, counted from the request or from the write that starts it. An error status is due one cycle after the request is accepted. Every write follows the previous one by exactly one cycle, except across the 1 µs gap. A `done` is due 20·CYC_PER_US+1 cycles after the final write, or two cycles after the final write when the monitor already matches. The bench logs every strobe and every `done` with a cycle stamp taken at the falling edge, then compares the differences against these counts, using a shortened CYC_PER_US so that the windows stay small.

// File: rtl/pll_rate_seq.sv
module pll_rate_seq #(
  parameter int CYC_PER_US = 50,
  parameter int PCW_W      = 22,
  parameter int PD_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_domain,
  input  logic [1:0]       req_mode,
  input  logic [PD_W-1:0]  req_postdiv,
  input  logic [PCW_W-1:0] req_pcw,
  output logic             busy,
  output logic             wr_en,
  output logic [2:0]       wr_kind,
  output logic [1:0]       wr_ch,
  output logic [31:0]      wr_data,
  input  logic [31:0]      mon_data,
  output logic             done,
  output logic [1:0]       status
);
  localparam int NCH   = 4;
  localparam int SHORT = CYC_PER_US;
  localparam int LONG  = 20 * CYC_PER_US;
  localparam int CNT_W = (LONG > 2) ? $clog2(LONG) : 1;
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG - 1);

  localparam logic [2:0] K_CTRL = 3'd0, K_DIV = 3'd1, K_SWT = 3'd2, K_HWT = 3'd3, K_EN = 3'd4;
  localparam logic [1:0] ST_OK = 2'd0, ST_DOM = 2'd1, ST_MODE = 2'd2, ST_TMO = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_DIR, S_SW_OFF, S_SW_TGT, S_SW_DIV, S_SW_TGL, S_SW_GAP, S_SW_ON,
    S_SETTLE, S_HW_A, S_HW_B, S_POLL
  } state_t;

  state_t           state;
  logic [1:0]       ch_q;
  logic [PD_W-1:0]  pd_q;
  logic [PCW_W-1:0] pcw_q;
  logic             up_q;
  logic [CNT_W-1:0] cnt;
  logic [PD_W-1:0]  shadow [NCH];

  logic       dom_ok;
  logic [1:0] dom_ch;
  logic       mon_hit;

  always_comb begin
    dom_ok = 1'b1;
    dom_ch = 2'd0;
    case (req_domain)
      3'd0, 3'd1: dom_ch = 2'd0;
      3'd2, 3'd3: dom_ch = 2'd1;
      3'd4:       dom_ch = 2'd2;
      3'd5:       dom_ch = 2'd3;
      default:    dom_ok = 1'b0;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign wr_ch   = ch_q;
  assign mon_hit = (mon_data[PCW_W-1:0] == pcw_q);

  logic [31:0] tgt_word, ctrl_word, div_word;
  assign tgt_word  = {1'b1, {(31-PCW_W){1'b0}}, pcw_q};
  assign ctrl_word = {1'b1, 4'b0, pd_q, {(24-PCW_W){1'b0}}, pcw_q};
  assign div_word  = {{(32-PD_W){1'b0}}, pd_q};

  always_comb begin
    wr_en   = 1'b1;
    wr_kind = K_CTRL;
    wr_data = 32'd0;
    case (state)
      S_DIR:    begin wr_kind = K_CTRL; wr_data = ctrl_word; end
      S_SW_OFF: begin wr_kind = K_EN;   wr_data = 32'd0; end
      S_SW_TGT: begin wr_kind = K_SWT;  wr_data = tgt_word; end
      S_SW_DIV: begin wr_kind = K_DIV;  wr_data = div_word; end
      S_SW_TGL: begin wr_kind = K_SWT;  wr_data = tgt_word | 32'h4000_0000; end
      S_SW_ON:  begin wr_kind = K_EN;   wr_data = 32'd1; end
      S_HW_A:   begin wr_kind = up_q ? K_DIV : K_HWT; wr_data = up_q ? div_word : tgt_word; end
      S_HW_B:   begin wr_kind = up_q ? K_HWT : K_DIV; wr_data = up_q ? tgt_word : div_word; end
      default:  wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ch_q   <= '0;
      pd_q   <= '0;
      pcw_q  <= '0;
      up_q   <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
      status <= ST_OK;
      for (int i = 0; i < NCH; i++) shadow[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (!dom_ok) begin
            done <= 1'b1; status <= ST_DOM;
          end else if (req_mode == 2'd3) begin
            done <= 1'b1; status <= ST_MODE;
          end else begin
            ch_q  <= dom_ch;
            pd_q  <= req_postdiv;
            pcw_q <= req_pcw;
            up_q  <= (req_postdiv > shadow[dom_ch]);
            case (req_mode)
              2'd0:    state <= S_DIR;
              2'd1:    state <= S_SW_OFF;
              default: state <= S_HW_A;
            endcase
          end
        end
        S_DIR: begin
          shadow[ch_q] <= pd_q;
          cnt   <= LONG_LD;
          state <= S_SETTLE;
        end
        S_SW_OFF: state <= S_SW_TGT;
        S_SW_TGT: state <= S_SW_DIV;
        S_SW_DIV: begin
          shadow[ch_q] <= pd_q;
          state <= S_SW_TGL;
        end
        S_SW_TGL: begin
          cnt   <= SHORT_LD;
          state <= S_SW_GAP;
        end
        S_SW_GAP: if (cnt == '0) state <= S_SW_ON; else cnt <= cnt - 1'b1;
        S_SW_ON: begin
          cnt   <= LONG_LD;
          state <= S_SETTLE;
        end
        S_SETTLE: if (cnt == '0) begin
          state <= S_IDLE; done <= 1'b1; status <= ST_OK;
        end else cnt <= cnt - 1'b1;
        S_HW_A: state <= S_HW_B;
        S_HW_B: begin
          shadow[ch_q] <= pd_q;
          cnt   <= LONG_LD;
          state <= S_POLL;
        end
        S_POLL: if (mon_hit) begin
          state <= S_IDLE; done <= 1'b1; status <= ST_OK;
        end else if (cnt == '0) begin
          state <= S_IDLE; done <= 1'b1; status <= ST_TMO;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R12
  ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_ch));
  // R2
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == ST_DOM || status == ST_MODE)) |-> !$past(wr_en));
  // R5
  toggle_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == K_SWT && wr_data[30]) |-> $past(wr_en && wr_kind == K_DIV));
  // R9
  mon_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_OK && $past(state == S_POLL)) |-> $past(mon_data[PCW_W-1:0] == pcw_q));
  // R10
  tmo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_TMO) |-> $past(state == S_POLL));
endmodule

// File: tb/pll_rate_seq_test.sv
module pll_rate_seq_test;
  localparam int C    = 5;
  localparam int LONG = 20 * C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_domain = '0;
  logic [1:0] req_mode = '0;
  logic [2:0] req_postdiv = '0;
  logic [21:0] req_pcw = '0;
  logic busy, wr_en, done;
  logic [2:0] wr_kind;
  logic [1:0] wr_ch, status;
  logic [31:0] wr_data, mon_data;

  always #10 clk = ~clk;

  logic [21:0] mon_q [4];
  logic stuck = 1'b0;
  assign mon_data = {10'b0, mon_q[wr_ch]};

  pll_rate_seq #(.CYC_PER_US(C)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_domain(req_domain),
    .req_mode(req_mode), .req_postdiv(req_postdiv), .req_pcw(req_pcw),
    .busy(busy), .wr_en(wr_en), .wr_kind(wr_kind), .wr_ch(wr_ch), .wr_data(wr_data),
    .mon_data(mon_data), .done(done), .status(status));

  int checks = 0, failures = 0, cyc = 0;
  int nlog = 0, done_cnt = 0, done_cyc = 0, req_cyc = 0;
  logic [1:0] done_st;
  logic [2:0] k_l [16];
  logic [31:0] d_l [16];
  logic [1:0] c_l [16];
  int t_l [16];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_en) begin
      if (nlog < 16) begin
        k_l[nlog] <= wr_kind; d_l[nlog] <= wr_data; c_l[nlog] <= wr_ch; t_l[nlog] <= cyc;
      end
      nlog <= nlog + 1;
      if (wr_kind == 3'd3) mon_q[wr_ch] <= stuck ? ~wr_data[21:0] : wr_data[21:0];
    end
    if (done) begin
      done_cnt <= done_cnt + 1; done_cyc <= cyc; done_st <= status;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] d, input logic [1:0] m, input logic [2:0] pd, input logic [21:0] pcw);
    @(posedge clk); #1;
    nlog = 0; done_cnt = 0;
    @(negedge clk);
    req_cyc = cyc;
    req_valid = 1'b1; req_domain = d; req_mode = m; req_postdiv = pd; req_pcw = pcw;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 3000) begin @(posedge clk); n++; end
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] tgt(input logic [21:0] p);
    return {1'b1, 9'b0, p};
  endfunction

  logic [2:0] sh [4];

  task automatic t_reset();
    #1;
    chk(!busy && !done && !wr_en, "R12", "reset outputs", {busy, done, wr_en}, 0);
  endtask

  task automatic t_direct();
    for (int d = 0; d < 6; d++) begin
      logic [1:0] ech = (d < 2) ? 2'd0 : (d < 4) ? 2'd1 : (d == 4) ? 2'd2 : 2'd3;
      logic [2:0] pd = 3'(d + 1);
      logic [21:0] pcw = 22'h2A5C3 + 22'(d * 4099);
      issue(3'(d), 2'd0, pd, pcw);
      wait_done();
      chk(nlog == 1 && k_l[0] == 3'd0, "R4", "direct write count/kind", nlog, 1);
      chk(d_l[0] == {1'b1, 4'b0, pd, 2'b0, pcw}, "R4", "direct word", d_l[0], {1'b1, 4'b0, pd, 2'b0, pcw});
      chk(c_l[0] == ech, "R1", "channel", c_l[0], ech);
      chk(done_cnt == 1 && done_st == 2'd0 && done_cyc - t_l[0] == LONG + 1, "R4", "settle latency",
          done_cyc - t_l[0], LONG + 1);
      sh[ech] = pd;
    end
  endtask

  task automatic t_bad();
    issue(3'd6, 2'd0, 3'd1, 22'h1);
    wait_done();
    chk(done_st == 2'd1 && nlog == 0 && done_cyc == req_cyc + 1, "R2", "domain 6", done_st, 1);
    issue(3'd7, 2'd3, 3'd1, 22'h1);
    wait_done();
    chk(done_st == 2'd1 && nlog == 0, "R2", "domain 7 priority over mode", done_st, 1);
    issue(3'd2, 2'd3, 3'd1, 22'h1);
    wait_done();
    chk(done_st == 2'd2 && nlog == 0 && done_cyc == req_cyc + 1, "R3", "bad mode", done_st, 2);
  endtask

  task automatic t_sw();
    logic [21:0] p = 22'h15B0F;
    issue(3'd3, 2'd1, 3'd5, p);
    wait_done();
    chk(nlog == 5, "R5", "write count", nlog, 5);
    chk(k_l[0] == 3'd4 && d_l[0] == 32'd0, "R5", "disable", d_l[0], 0);
    chk(k_l[1] == 3'd2 && d_l[1] == tgt(p), "R5", "target", d_l[1], tgt(p));
    chk(k_l[2] == 3'd1 && d_l[2] == 32'd5, "R5", "divider", d_l[2], 5);
    chk(k_l[3] == 3'd2 && d_l[3] == (tgt(p) | 32'h4000_0000), "R5", "toggle", d_l[3], tgt(p) | 32'h4000_0000);
    chk(k_l[4] == 3'd4 && d_l[4] == 32'd1, "R5", "enable", d_l[4], 1);
    chk(t_l[3] - t_l[0] == 3, "R5", "back-to-back", t_l[3] - t_l[0], 3);
    chk(t_l[4] - t_l[3] == C + 1, "R6", "1us gap", t_l[4] - t_l[3], C + 1);
    chk(done_st == 2'd0 && done_cyc - t_l[4] == LONG + 1, "R6", "settle", done_cyc - t_l[4], LONG + 1);
    chk(c_l[4] == 2'd1, "R1", "sw channel", c_l[4], 1);
    sh[1] = 3'd5;
  endtask

  task automatic t_hw(input logic [2:0] d, input logic [2:0] pd, input logic [21:0] p, input bit expect_up,
                      input string rq);
    issue(d, 2'd2, pd, p);
    wait_done();
    chk(nlog == 2, rq, "hw write count", nlog, 2);
    if (expect_up)
      chk(k_l[0] == 3'd1 && k_l[1] == 3'd3, rq, "divider then target", {k_l[0], k_l[1]}, {3'd1, 3'd3});
    else
      chk(k_l[0] == 3'd3 && k_l[1] == 3'd1, rq, "target then divider", {k_l[0], k_l[1]}, {3'd3, 3'd1});
    chk(d_l[expect_up ? 1 : 0] == tgt(p), rq, "hw target word", d_l[expect_up ? 1 : 0], tgt(p));
    chk(d_l[expect_up ? 0 : 1] == {29'b0, pd}, rq, "hw divider word", d_l[expect_up ? 0 : 1], pd);
    if (!stuck)
      chk(done_st == 2'd0 && done_cyc - t_l[1] == 2, "R9", "monitor match", done_cyc - t_l[1], 2);
    else
      chk(done_st == 2'd3 && done_cyc - t_l[1] == LONG + 1, "R10", "timeout", done_cyc - t_l[1], LONG + 1);
  endtask

  task automatic t_busy();
    issue(3'd5, 2'd0, 3'd2, 22'h0ABCD);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy during settle", busy, 1);
    req_valid = 1'b1; req_domain = 3'd0; req_mode = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk(done_cnt == 1 && nlog == 1 && done_st == 2'd0, "R11", "ignored request", done_cnt, 1);
    chk(c_l[0] == 2'd3 && !busy, "R11", "channel and idle", c_l[0], 3);
    sh[3] = 3'd2;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mon_q[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_direct();
    t_bad();
    t_sw();
    t_hw(3'd0, 3'd4, 22'h3F00A, 1'b1, "R7");
    t_hw(3'd1, 3'd1, 22'h01234, 1'b0, "R8");
    t_hw(3'd0, 3'd1, 22'h04321, 1'b0, "R8");
    stuck = 1'b1;
    t_hw(3'd4, 3'd3, 22'h22222, 1'b0, "R10");
    stuck = 1'b0;
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule